// File: doc/BRIEF.md
# Working Register File with Data-Space Decoder

The block stores thirty-two 8-bit working registers for a small processor core. The execution unit uses two combinational read ports and one clocked write port. Each register can hold either an operand or one byte of an address. The three highest register pairs are always visible as 16-bit pointer outputs.

A second, byte-wide data-space port lets load/store logic reach the same registers as memory locations. The decoder splits the 16-bit data-space address into three regions. The lowest 32 addresses reach the register file. The next 64 addresses are forwarded to an external I/O bus with a zero-based index. The 128 addresses above those reach an internal SRAM that also holds the stack. Addresses above the SRAM read as zero and discard writes.

Top module: `dspace_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all 32 registers, so both read ports and all three pointer outputs show zero.
- R2: Each read port returns the selected register combinationally. An execution-unit write (`ex_we`) is not visible before the next rising clock edge and is visible right after it.
- R3: `ptr_x` is {R27,R26}, `ptr_y` is {R29,R28} and `ptr_z` is {R31,R30}, with the higher-numbered register as the upper byte.
- R4: Data-space addresses 0x0000 to 0x001F address register N = address. A data-space write there changes that register, and a data-space read returns it.
- R5: Data-space addresses 0x0020 to 0x005F drive `io_idx` = address − 0x20. They pass `ds_we`/`ds_re` to `io_we`/`io_re` and `ds_wdata` to `io_wdata`, and a read returns `io_rdata`.
- R6: Data-space addresses 0x0060 to 0x00DF address SRAM byte (address − 0x60). A write is stored at the clock edge, and a later read returns it.
- R7: A read from any address above 0x00DF returns 0x00. A write there changes no register and no SRAM byte.
- R8: When an execution-unit write and a data-space write hit the same register in one cycle, the register takes the execution-unit data. Writes to different registers in one cycle both take effect.
- R9: `io_we` and `io_re` stay low whenever the data-space address lies outside 0x0020 to 0x005F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_ra_sel | input | 5 | Read port A register select |
| ex_ra_data | output | 8 | Read port A data |
| ex_rb_sel | input | 5 | Read port B register select |
| ex_rb_data | output | 8 | Read port B data |
| ex_we | input | 1 | Execution-unit write enable |
| ex_wsel | input | 5 | Execution-unit write register select |
| ex_wdata | input | 8 | Execution-unit write data |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write strobe |
| ds_re | input | 1 | Data-space read strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| io_idx | output | 6 | I/O bus location index |
| io_we | output | 1 | I/O bus write strobe |
| io_re | output | 1 | I/O bus read strobe |
| io_wdata | output | 8 | I/O bus write data |
| io_rdata | input | 8 | I/O bus read data |
| ptr_x | output | 16 | Pointer formed by R27:R26 |
| ptr_y | output | 16 | Pointer formed by R29:R28 |
| ptr_z | output | 16 | Pointer formed by R31:R30 |

## Verification
The register array drives the read ports and pointers through combinational logic. A wrong register value therefore shows up at `ex_ra_data`, `ex_rb_data` or a pointer output within the same cycle it is selected. It also shows up on `ds_rdata` as soon as its data-space address is presented. A mis-decoded address shows at once on the I/O strobes, or on a read-back one clock after the misdirected write. An SRAM byte corrupted by an out-of-range write stays hidden until that byte is read. For that reason the bench reads back a neighbouring SRAM byte and register after every unmapped write.

// File: rtl/dspace_regfile.sv
module dspace_regfile #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NREG      = 32,
  parameter int unsigned IO_BASE   = 32,
  parameter int unsigned IO_N      = 64,
  parameter int unsigned SRAM_BASE = 96,
  parameter int unsigned SRAM_N    = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NREG)-1:0]    ex_ra_sel,
  output logic [DATA_W-1:0]          ex_ra_data,
  input  logic [$clog2(NREG)-1:0]    ex_rb_sel,
  output logic [DATA_W-1:0]          ex_rb_data,
  input  logic                       ex_we,
  input  logic [$clog2(NREG)-1:0]    ex_wsel,
  input  logic [DATA_W-1:0]          ex_wdata,
  input  logic [ADDR_W-1:0]          ds_addr,
  input  logic                       ds_we,
  input  logic                       ds_re,
  input  logic [DATA_W-1:0]          ds_wdata,
  output logic [DATA_W-1:0]          ds_rdata,
  output logic [$clog2(IO_N)-1:0]    io_idx,
  output logic                       io_we,
  output logic                       io_re,
  output logic [DATA_W-1:0]          io_wdata,
  input  logic [DATA_W-1:0]          io_rdata,
  output logic [2*DATA_W-1:0]        ptr_x,
  output logic [2*DATA_W-1:0]        ptr_y,
  output logic [2*DATA_W-1:0]        ptr_z
);
  localparam int unsigned REG_AW  = $clog2(NREG);
  localparam int unsigned IO_AW   = $clog2(IO_N);
  localparam int unsigned SRAM_AW = $clog2(SRAM_N);
  localparam logic [ADDR_W-1:0] REG_END  = ADDR_W'(NREG);
  localparam logic [ADDR_W-1:0] IO_LO    = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] IO_END   = ADDR_W'(IO_BASE + IO_N);
  localparam logic [ADDR_W-1:0] SRAM_LO  = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] SRAM_END = ADDR_W'(SRAM_BASE + SRAM_N);
  localparam logic [IO_AW-1:0]   IO_OFS   = IO_AW'(IO_BASE);
  localparam logic [SRAM_AW-1:0] SRAM_OFS = SRAM_AW'(SRAM_BASE);

  logic [DATA_W-1:0] rf  [NREG];
  logic [DATA_W-1:0] mem [SRAM_N];

  logic in_reg, in_io, in_sram;
  logic [REG_AW-1:0]  reg_idx;
  logic [SRAM_AW-1:0] sram_idx;

  assign in_reg   = ds_addr < REG_END;
  assign in_io    = (ds_addr >= IO_LO) && (ds_addr < IO_END);
  assign in_sram  = (ds_addr >= SRAM_LO) && (ds_addr < SRAM_END);
  assign reg_idx  = ds_addr[REG_AW-1:0];
  assign sram_idx = ds_addr[SRAM_AW-1:0] - SRAM_OFS;

  assign io_idx   = ds_addr[IO_AW-1:0] - IO_OFS;
  assign io_we    = ds_we & in_io;
  assign io_re    = ds_re & in_io;
  assign io_wdata = ds_wdata;

  assign ex_ra_data = rf[ex_ra_sel];
  assign ex_rb_data = rf[ex_rb_sel];

  assign ptr_x = {rf[27], rf[26]};
  assign ptr_y = {rf[29], rf[28]};
  assign ptr_z = {rf[31], rf[30]};

  always_comb begin
    ds_rdata = '0;
    if (in_reg)       ds_rdata = rf[reg_idx];
    else if (in_io)   ds_rdata = io_rdata;
    else if (in_sram) ds_rdata = mem[sram_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (ds_we && in_reg) rf[reg_idx] <= ds_wdata;
      if (ex_we)           rf[ex_wsel] <= ex_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ds_we && in_sram) mem[sram_idx] <= ds_wdata;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0 && ex_ra_data == rf[ex_ra_sel]));

  assert_ex_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ex_we |=> rf[$past(ex_wsel)] == $past(ex_wdata));

  assert_ds_reg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_we && in_reg && !(ex_we && ex_wsel == reg_idx))
      |=> rf[$past(reg_idx)] == $past(ds_wdata));

  assert_sram_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_we && in_sram) |=> mem[$past(sram_idx)] == $past(ds_wdata));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_addr >= SRAM_END) |-> ds_rdata == '0);

  assert_unmapped_ptr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_we && ds_addr >= SRAM_END && !ex_we) |=> $stable(ptr_z) && $stable(ptr_x));

  assert_io_strobe_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we || io_re) |-> (ds_addr >= IO_LO && ds_addr < IO_END));
endmodule

// File: tb/test_dspace_regfile.sv
module test_dspace_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ex_ra_sel = '0, ex_rb_sel = '0, ex_wsel = '0;
  logic [7:0] ex_wdata = '0, ds_wdata = '0;
  logic ex_we = 1'b0, ds_we = 1'b0, ds_re = 1'b0;
  logic [15:0] ds_addr = '0;
  logic [7:0] ex_ra_data, ex_rb_data, ds_rdata, io_wdata, io_rdata;
  logic [5:0] io_idx;
  logic io_we, io_re;
  logic [15:0] ptr_x, ptr_y, ptr_z;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign io_rdata = {2'b00, io_idx} ^ 8'hA5;

  dspace_regfile i_dspace_regfile (
    .clk(clk), .rst_n(rst_n),
    .ex_ra_sel(ex_ra_sel), .ex_ra_data(ex_ra_data),
    .ex_rb_sel(ex_rb_sel), .ex_rb_data(ex_rb_data),
    .ex_we(ex_we), .ex_wsel(ex_wsel), .ex_wdata(ex_wdata),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_re(ds_re),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .io_idx(io_idx), .io_we(io_we), .io_re(io_re),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ex_write(logic [4:0] sel, logic [7:0] d);
    @(negedge clk);
    ex_we = 1'b1; ex_wsel = sel; ex_wdata = d;
    @(negedge clk);
    ex_we = 1'b0;
  endtask

  task automatic ds_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    ds_we = 1'b1; ds_addr = a; ds_wdata = d;
    @(negedge clk);
    ds_we = 1'b0;
  endtask

  task automatic ds_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ds_re = 1'b1; ds_addr = a;
    #1 d = ds_rdata;
    ds_re = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] sel, output logic [7:0] d);
    ex_ra_sel = sel;
    #1 d = ex_ra_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(5'd9, d);
    check("R1 reg9 after reset", d, 8'h00);
    ex_rb_sel = 5'd31;
    #1 check("R1 portB r31 after reset", ex_rb_data, 8'h00);
    check("R1 ptr_x", ptr_x, 16'h0);
    check("R1 ptr_y", ptr_y, 16'h0);
    check("R1 ptr_z", ptr_z, 16'h0);
  endtask

  task automatic t_ex_rw;
    logic [7:0] d;
    @(negedge clk);
    ex_we = 1'b1; ex_wsel = 5'd3; ex_wdata = 8'h5A;
    ex_ra_sel = 5'd3;
    #1 check("R2 no write before edge", ex_ra_data, 8'h00);
    @(negedge clk);
    ex_we = 1'b0;
    #1 check("R2 write visible after edge", ex_ra_data, 8'h5A);
    ex_write(5'd17, 8'hC3);
    ex_rb_sel = 5'd17;
    rd_reg(5'd3, d);
    check("R2 port A r3", d, 8'h5A);
    check("R2 port B r17", ex_rb_data, 8'hC3);
  endtask

  task automatic t_pointers;
    ex_write(5'd26, 8'h11); ex_write(5'd27, 8'h22);
    ex_write(5'd28, 8'h33); ex_write(5'd29, 8'h44);
    ex_write(5'd30, 8'h55); ex_write(5'd31, 8'h66);
    #1;
    check("R3 ptr_x = R27:R26", ptr_x, 16'h2211);
    check("R3 ptr_y = R29:R28", ptr_y, 16'h4433);
    check("R3 ptr_z = R31:R30", ptr_z, 16'h6655);
  endtask

  task automatic t_ds_reg;
    logic [7:0] d;
    ds_write(16'h0008, 8'h9E);
    rd_reg(5'd8, d);
    check("R4 ds write to r8", d, 8'h9E);
    ds_read(16'h0011, d);
    check("R4 ds read of r17", d, 8'hC3);
    ds_write(16'h001E, 8'hAB);
    #1 check("R4 ds write r30 seen on ptr_z", ptr_z, 16'h66AB);
  endtask

  task automatic t_io;
    logic [7:0] d;
    @(negedge clk);
    ds_addr = 16'h0020; ds_re = 1'b1;
    #1;
    check("R5 io_idx at 0x20", io_idx, 6'd0);
    check("R5 io_re in window", io_re, 1'b1);
    check("R5 read returns io_rdata", ds_rdata, 8'hA5);
    ds_re = 1'b0;
    @(negedge clk);
    ds_addr = 16'h005F; ds_we = 1'b1; ds_wdata = 8'h7E;
    #1;
    check("R5 io_idx at 0x5F", io_idx, 6'd63);
    check("R5 io_we in window", io_we, 1'b1);
    check("R5 io_wdata", io_wdata, 8'h7E);
    ds_addr = 16'h001F;
    #1 check("R9 io_we low at 0x1F", io_we, 1'b0);
    ds_addr = 16'h0060;
    #1 check("R9 io_we low at 0x60", io_we, 1'b0);
    ds_we = 1'b0;
    ds_read(16'h0045, d);
    check("R5 read at 0x45", d, 8'hA5 ^ 8'h25);
  endtask

  task automatic t_sram;
    logic [7:0] d;
    ds_write(16'h0060, 8'h3C);
    ds_write(16'h00DF, 8'hD7);
    ds_write(16'h0090, 8'h42);
    ds_read(16'h0060, d);
    check("R6 sram first byte", d, 8'h3C);
    ds_read(16'h00DF, d);
    check("R6 sram last byte", d, 8'hD7);
    ds_read(16'h0090, d);
    check("R6 sram middle byte", d, 8'h42);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    ex_write(5'd0, 8'h11);
    ds_write(16'h00E0, 8'hFF);
    ds_write(16'h0100, 8'hEE);
    ds_write(16'hFFFF, 8'hDD);
    ds_read(16'h0060, d);
    check("R7 sram 0x60 untouched", d, 8'h3C);
    ds_read(16'h00DF, d);
    check("R7 sram 0xDF untouched", d, 8'hD7);
    rd_reg(5'd0, d);
    check("R7 r0 untouched", d, 8'h11);
    ds_read(16'h00E0, d);
    check("R7 read 0xE0 zero", d, 8'h00);
    ds_read(16'hFFFF, d);
    check("R7 read 0xFFFF zero", d, 8'h00);
    #1 check("R9 io_re low at 0xFFFF", io_re, 1'b0);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    @(negedge clk);
    ex_we = 1'b1; ex_wsel = 5'd5; ex_wdata = 8'hAA;
    ds_we = 1'b1; ds_addr = 16'h0005; ds_wdata = 8'h55;
    @(negedge clk);
    ex_wsel = 5'd6; ex_wdata = 8'h66;
    ds_addr = 16'h0007; ds_wdata = 8'h77;
    @(negedge clk);
    ex_we = 1'b0; ds_we = 1'b0;
    rd_reg(5'd5, d);
    check("R8 same reg: ex wins", d, 8'hAA);
    rd_reg(5'd6, d);
    check("R8 ex write r6", d, 8'h66);
    rd_reg(5'd7, d);
    check("R8 ds write r7", d, 8'h77);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_ex_rw();
    t_pointers();
    t_ds_reg();
    t_io();
    t_sram();
    t_unmapped();
    t_collision();
    @(negedge clk);
    rst_n = 1'b0;
    #1 t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule